// File: doc/BRIEF.md
# Length-Aware Vector Spill Engine

This block moves one variable-length vector register between the core and a vector stack held in data memory. The stack is separate from the scalar stack. Each register carries a used length in bytes. A spill writes only that length and the lines that hold live bytes. A fill reads the length back and then reads only the lines that length covers.

Before any spill or fill, the block rounds the incoming vector stack pointer up to the next line boundary. It reports the padding it added so that software can keep that value on the scalar stack. The record starts with a header line. The length sits in bits [63:0] of that line and the rest of the line is zero. The data lines follow at consecutive line addresses. Each line moves in one single-beat memory access.

A command is one start pulse with an operation select. Completion is one done pulse that carries the new pointer, the pad and an error flag. A fill given the same pointer that the matching spill received finds the same record.

Top module: `vspill_engine`

## Requirements
- R1: Every memory access uses a line-aligned address (64-byte lines, low 6 address bits zero). The record base is the input pointer rounded up to the next multiple of 64. `pad_o` equals base minus input pointer, in the range 0..63.
- R2: A spill first writes the header line at the base, with the length in bits [63:0] and zeros above. It then writes ceil(len/64) data lines at base+64, base+128, and so on. Bytes at or past the length are written as zero.
- R3: A length of zero issues only the header access, with no data beats, for both spill and fill.
- R4: On a successful command, `vsp_o` at done equals base + 64 × (1 + number of data lines), which is the input pointer plus exactly the bytes consumed.
- R5: A fill reads the header at the base and then ceil(header/64) data lines. `vlen_o` then equals the header, and every byte of `vreg_o` at or past that length reads zero.
- R6: A start pulse while the block is busy is ignored and does not change the running command or its result.
- R7: `busy_o` is high from the cycle after an accepted start through the done cycle. `done_o` is a single-cycle pulse.
- R8: A spill with `vlen_i` above 256 bytes (4 lines) issues no memory access. Done then reports `err_o`=1, `vsp_o` equal to the input pointer, and `pad_o`=0.
- R9: A fill whose header exceeds 256 issues no data reads. Done then reports `err_o`=1, `vsp_o` equal to the input pointer, `pad_o`=0, `vlen_o`=0 and an all-zero `vreg_o`.
- R10: A memory request holds its address, write enable and write data unchanged until `mem_ack_i` is seen. A beat completes on the clock edge where request and ack are both high, and read data is sampled on that edge.
- R11: After reset the block is idle, with no request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, sampled while idle |
| save_i | input | 1 | 1 = spill, 0 = fill |
| vsp_i | input | 32 | Vector stack pointer before the command |
| vlen_i | input | 9 | Used length in bytes of the register to spill |
| vdata_i | input | 2048 | Register contents to spill |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Length out of range on last command |
| vsp_o | output | 32 | Pointer after the command |
| pad_o | output | 6 | Bytes of alignment padding inserted |
| vlen_o | output | 9 | Length restored by the last fill |
| vreg_o | output | 2048 | Restored register, zero past the length |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 = write beat |
| mem_addr_o | output | 32 | Line-aligned byte address |
| mem_wdata_o | output | 512 | Write line |
| mem_rdata_i | input | 512 | Read line, valid with ack |
| mem_ack_i | input | 1 | Beat accepted |

## Verification
The bound checker watches several properties on every cycle. It checks that every memory address is line-aligned and that a stalled request holds its address and data. It also checks that done lasts one cycle, that an idle block is silent on the memory port, and that a command cannot end early once busy. It checks that an error completion reports zero pad and zero length, and that a good completion leaves an aligned pointer. Other behaviour shows only in the bench's scenarios. These are the beat count per length, the exact address order, the header and zeroed tail in memory, the zero-fill of a fill against a record with garbage tail bytes, and round trips of randomly placed registers under random ack stalls. The bench also injects a start during a busy command and confirms it has no effect.

// File: rtl/vspill_pkg.sv
package vspill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_FIN
  } vspill_state_e;
endpackage

// File: rtl/vspill_align.sv
module vspill_align #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFS_W     = $clog2(LINE_BYTES)
) (
  input  logic [ADDR_W-1:0] vsp_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [OFS_W-1:0]  pad_o
);
  // distance to next boundary is the two's complement of the line offset
  assign pad_o  = OFS_W'(0) - vsp_i[OFS_W-1:0];
  assign base_o = vsp_i + ADDR_W'(pad_o);
endmodule

// File: rtl/vspill_line_cnt.sv
module vspill_line_cnt #(
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 9,
  parameter int CNT_W      = 3,
  localparam int OFS_W     = $clog2(LINE_BYTES)
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] lines_o
);
  assign lines_o = CNT_W'(({1'b0, len_i} + (LEN_W+1)'(LINE_BYTES-1)) >> OFS_W);
endmodule

// File: rtl/vspill_byte_mask.sv
module vspill_byte_mask #(
  parameter int MAX_BYTES = 256,
  parameter int LEN_W     = 9,
  localparam int VEC_W    = MAX_BYTES*8
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [VEC_W-1:0] mask_o
);
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    assign mask_o[b*8 +: 8] = {8{LEN_W'(b) < len_i}};
  end
endmodule

// File: rtl/vspill_engine.sv
module vspill_engine
  import vspill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LINES  = 4,
  parameter int HDR_W      = 64,
  localparam int LINE_W    = LINE_BYTES*8,
  localparam int MAX_BYTES = LINE_BYTES*MAX_LINES,
  localparam int VEC_W     = MAX_BYTES*8,
  localparam int LEN_W     = $clog2(MAX_BYTES+1),
  localparam int OFS_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = $clog2(MAX_LINES+1),
  localparam int IDX_W     = $clog2(MAX_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              save_i,
  input  logic [ADDR_W-1:0] vsp_i,
  input  logic [LEN_W-1:0]  vlen_i,
  input  logic [VEC_W-1:0]  vdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] vsp_o,
  output logic [OFS_W-1:0]  pad_o,
  output logic [LEN_W-1:0]  vlen_o,
  output logic [VEC_W-1:0]  vreg_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic [LINE_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  vspill_state_e     state_q;
  logic              save_q, err_q;
  logic [ADDR_W-1:0] vsp_q, base_q;
  logic [OFS_W-1:0]  pad_q;
  logic [LEN_W-1:0]  len_q;
  logic [CNT_W-1:0]  lines_q, idx_q;
  logic [LINE_W-1:0] data_q [MAX_LINES];

  logic [ADDR_W-1:0] base_in;
  logic [OFS_W-1:0]  pad_in;
  logic [CNT_W-1:0]  lines_in, lines_hdr;
  logic [VEC_W-1:0]  mask_in, mask_q;
  logic [HDR_W-1:0]  hdr_val;
  logic              len_over, hdr_over, beat;

  vspill_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .vsp_i(vsp_i), .base_o(base_in), .pad_o(pad_in)
  );
  vspill_line_cnt #(.LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt_in (
    .len_i(vlen_i), .lines_o(lines_in)
  );
  vspill_line_cnt #(.LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_cnt_hdr (
    .len_i(hdr_val[LEN_W-1:0]), .lines_o(lines_hdr)
  );
  vspill_byte_mask #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_mask_in (
    .len_i(vlen_i), .mask_o(mask_in)
  );
  vspill_byte_mask #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_mask_q (
    .len_i(len_q), .mask_o(mask_q)
  );

  assign hdr_val  = mem_rdata_i[HDR_W-1:0];
  assign hdr_over = hdr_val > HDR_W'(MAX_BYTES);
  assign len_over = vlen_i > LEN_W'(MAX_BYTES);
  assign beat     = mem_req_o && mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      save_q  <= 1'b0;
      err_q   <= 1'b0;
      vsp_q   <= '0;
      base_q  <= '0;
      pad_q   <= '0;
      len_q   <= '0;
      lines_q <= '0;
      idx_q   <= '0;
      for (int l = 0; l < MAX_LINES; l++) data_q[l] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          save_q <= save_i;
          vsp_q  <= vsp_i;
          base_q <= base_in;
          pad_q  <= pad_in;
          idx_q  <= '0;
          err_q  <= 1'b0;
          if (save_i && !len_over) begin
            len_q   <= vlen_i;
            lines_q <= lines_in;
            for (int l = 0; l < MAX_LINES; l++)
              data_q[l] <= vdata_i[l*LINE_W +: LINE_W] & mask_in[l*LINE_W +: LINE_W];
            state_q <= ST_HDR;
          end else begin
            len_q   <= '0;
            lines_q <= '0;
            for (int l = 0; l < MAX_LINES; l++) data_q[l] <= '0;
            err_q   <= save_i;
            state_q <= save_i ? ST_FIN : ST_HDR;
          end
        end
        ST_HDR: if (beat) begin
          if (save_q) begin
            state_q <= (lines_q == '0) ? ST_FIN : ST_DATA;
          end else if (hdr_over) begin
            err_q   <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            len_q   <= hdr_val[LEN_W-1:0];
            lines_q <= lines_hdr;
            state_q <= (lines_hdr == '0) ? ST_FIN : ST_DATA;
          end
        end
        ST_DATA: if (beat) begin
          if (!save_q) data_q[idx_q[IDX_W-1:0]] <= mem_rdata_i;
          idx_q <= idx_q + CNT_W'(1);
          if (idx_q + CNT_W'(1) == lines_q) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = state_q == ST_FIN;
  assign err_o      = err_q;
  assign pad_o      = err_q ? '0 : pad_q;
  assign vsp_o      = err_q ? vsp_q
                            : base_q + (ADDR_W'(lines_q + CNT_W'(1)) << OFS_W);
  assign vlen_o     = len_q;
  assign mem_req_o  = (state_q == ST_HDR) || (state_q == ST_DATA);
  assign mem_we_o   = save_q;
  assign mem_addr_o = (state_q == ST_DATA) ? base_q + (ADDR_W'(idx_q + CNT_W'(1)) << OFS_W)
                                           : base_q;
  assign mem_wdata_o = (state_q == ST_DATA) ? data_q[idx_q[IDX_W-1:0]]
                                            : LINE_W'(HDR_W'(len_q));

  for (genvar l = 0; l < MAX_LINES; l++) begin : g_out
    assign vreg_o[l*LINE_W +: LINE_W] = data_q[l] & mask_q[l*LINE_W +: LINE_W];
  end
endmodule

// File: rtl/vspill_engine_chk.sv
module vspill_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 512,
  parameter int OFS_W  = 6,
  parameter int LEN_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] vsp_o,
  input logic [OFS_W-1:0]  pad_o,
  input logic [LEN_W-1:0]  vlen_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LINE_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  assert_addr_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[OFS_W-1:0] == '0);

  assert_final_ptr_aligned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> vsp_o[OFS_W-1:0] == '0);

  assert_no_early_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_report_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> pad_o == '0 && vlen_o == '0);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !done_o);
endmodule

bind vspill_engine vspill_engine_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .OFS_W(OFS_W), .LEN_W(LEN_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .vsp_o(vsp_o), .pad_o(pad_o), .vlen_o(vlen_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
);

// File: tb/vspill_engine_tb_top.sv
`timescale 1ns/1ps
module vspill_engine_tb_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, save = 1'b0;
  logic [31:0]   vsp = '0;
  logic [8:0]    vlen = '0;
  logic [2047:0] vdata = '0;
  logic          busy, done, err;
  logic [31:0]   vsp_out;
  logic [5:0]    pad;
  logic [8:0]    vlen_out;
  logic [2047:0] vreg;
  logic          req, we, ack = 1'b0;
  logic [31:0]   addr;
  logic [511:0]  wdata, rdata;

  logic [511:0]  mem [64];
  int            checks = 0, fails = 0, cycles = 0;
  int            beats = 0, addr_bad = 0;
  logic [31:0]   exp_base = '0;
  logic          exp_we = 1'b0;
  logic          pre_req = 1'b0;
  logic [5:0]    pre_idx = '0;
  logic [511:0]  pre_val = '0;

  always #4 clk = ~clk;

  vspill_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .save_i(save), .vsp_i(vsp),
    .vlen_i(vlen), .vdata_i(vdata), .busy_o(busy), .done_o(done), .err_o(err),
    .vsp_o(vsp_out), .pad_o(pad), .vlen_o(vlen_out), .vreg_o(vreg),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .mem_ack_i(ack)
  );

  assign rdata = mem[addr[11:6]];

  // memory model: decides ack and commits beats between edges
  always @(negedge clk) begin
    ack = ($urandom % 4) != 0;
    #1;
    if (pre_req) mem[pre_idx] = pre_val;
    if (req && ack) begin
      if (addr != exp_base + 32'(beats) * 64 || we != exp_we) addr_bad++;
      if (we) mem[addr[11:6]] = wdata;
      beats++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_base(logic [31:0] v);
    return (v + 32'd63) & ~32'd63;
  endfunction
  function automatic int f_lines(int len);
    return (len + 63) / 64;
  endfunction
  function automatic logic [2047:0] f_mask(logic [2047:0] d, int len);
    for (int b = 0; b < 256; b++) if (b >= len) d[b*8 +: 8] = 8'h00;
    return d;
  endfunction

  task automatic preset(input int idx, input logic [511:0] val);
    pre_idx = 6'(idx); pre_val = val; pre_req = 1'b1;
    @(negedge clk); #2; pre_req = 1'b0;
  endtask

  // issue one command; optionally fire a stray start while busy
  task automatic run_op(input bit sv, input logic [31:0] p, input int len,
                        input logic [2047:0] d, input bit poke);
    int n = 0;
    @(negedge clk); #2;
    exp_base = f_base(p); exp_we = sv; beats = 0; addr_bad = 0;
    start = 1'b1; save = sv; vsp = p; vlen = 9'(len); vdata = d;
    @(negedge clk); #2;
    start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", 64'(busy), 64'd1);
    if (poke && !done) begin
      start = 1'b1; save = !sv; vsp = p + 32'd200; vlen = 9'd17; vdata = ~d;
      @(negedge clk); #2;
      start = 1'b0;
    end
    while (!done && n < 400) begin
      @(negedge clk); #2; n++;
    end
    chk(done == 1'b1, "R7", "done reached", 64'(done), 64'd1);
  endtask

  task automatic done_gone();
    @(negedge clk); #2;
    chk(done == 1'b0, "R7", "done single cycle", 64'(done), 64'd0);
  endtask

  task automatic save_and_check(input logic [31:0] p, input int len,
                                input logic [2047:0] d, input bit poke);
    logic [31:0]   b = f_base(p);
    int            nl = f_lines(len);
    logic [2047:0] md = f_mask(d, len);
    int            hi = int'(b[11:6]);
    run_op(1'b1, p, len, d, poke);
    chk(err == 1'b0, "R2", "save err", 64'(err), 64'd0);
    chk(pad == 6'(b - p), "R1", "pad", 64'(pad), 64'(b - p));
    chk(beats == 1 + nl, nl == 0 ? "R3" : "R2", "save beat count", 64'(beats), 64'(1 + nl));
    chk(addr_bad == 0, "R1", "address sequence", 64'(addr_bad), 64'd0);
    chk(vsp_out == b + 32'(64 * (1 + nl)), "R4", "vsp after save", 64'(vsp_out),
        64'(b + 32'(64 * (1 + nl))));
    chk(mem[hi] == 512'(64'(len)), "R2", "header line", mem[hi][63:0], 64'(len));
    for (int l = 0; l < nl; l++)
      chk(mem[hi + 1 + l] == md[l*512 +: 512], "R2", "data line", mem[hi + 1 + l][511:448],
          md[l*512 + 448 +: 64]);
    if (poke)
      chk(beats == 1 + nl && vsp_out == b + 32'(64 * (1 + nl)), "R6", "stray start ignored",
          64'(vsp_out), 64'(b + 32'(64 * (1 + nl))));
    done_gone();
  endtask

  task automatic restore_and_check(input logic [31:0] p, input int len,
                                   input logic [2047:0] md);
    logic [31:0] b = f_base(p);
    int          nl = f_lines(len);
    run_op(1'b0, p, 0, '0, 1'b0);
    chk(err == 1'b0, "R5", "restore err", 64'(err), 64'd0);
    chk(beats == 1 + nl, nl == 0 ? "R3" : "R5", "restore beat count", 64'(beats), 64'(1 + nl));
    chk(addr_bad == 0, "R1", "restore addresses", 64'(addr_bad), 64'd0);
    chk(vlen_out == 9'(len), "R5", "restored length", 64'(vlen_out), 64'(len));
    chk(vreg == md, "R5", "restored data", vreg[63:0], md[63:0]);
    chk(vsp_out == b + 32'(64 * (1 + nl)), "R4", "vsp after restore", 64'(vsp_out),
        64'(b + 32'(64 * (1 + nl))));
    done_gone();
  endtask

  function automatic logic [2047:0] rand_vec();
    logic [2047:0] d;
    for (int k = 0; k < 64; k++) d[k*32 +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    logic [2047:0] d;
    int            lens [9] = '{0, 1, 63, 64, 65, 128, 200, 255, 256};
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy == 1'b0 && done == 1'b0 && req == 1'b0, "R11", "reset idle",
        {61'd0, busy, done, req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(busy == 1'b0 && req == 1'b0, "R11", "idle after reset", {62'd0, busy, req}, 64'd0);

    // R3: zero length at unaligned pointer
    d = rand_vec();
    save_and_check(32'd65, 0, d, 1'b0);
    restore_and_check(32'd65, 0, '0);

    // R1: already aligned pointer, full length
    d = rand_vec();
    save_and_check(32'd256, 256, d, 1'b0);
    restore_and_check(32'd256, 256, d);

    // R6: stray start during spill
    d = rand_vec();
    save_and_check(32'd701, 130, d, 1'b1);
    restore_and_check(32'd701, 130, f_mask(d, 130));

    // R8: oversize spill
    run_op(1'b1, 32'd333, 257, rand_vec(), 1'b0);
    chk(err == 1'b1, "R8", "save err flag", 64'(err), 64'd1);
    chk(beats == 0, "R8", "no beats", 64'(beats), 64'd0);
    chk(vsp_out == 32'd333 && pad == 6'd0, "R8", "ptr unchanged", 64'(vsp_out), 64'd333);
    done_gone();

    // R9: header out of range
    preset(55, 512'(64'd300));
    run_op(1'b0, 32'd3500, 0, '0, 1'b0);
    chk(err == 1'b1, "R9", "restore err flag", 64'(err), 64'd1);
    chk(beats == 1, "R9", "header only", 64'(beats), 64'd1);
    chk(vsp_out == 32'd3500 && pad == 6'd0, "R9", "ptr unchanged", 64'(vsp_out), 64'd3500);
    chk(vlen_out == 9'd0 && vreg == '0, "R9", "zero result", 64'(vlen_out), 64'd0);
    done_gone();

    // R5: record with garbage past its length
    preset(50, 512'(64'd70));
    preset(51, {512{1'b1}});
    preset(52, {512{1'b1}});
    preset(53, {512{1'b1}});
    restore_and_check(32'd3200, 70, f_mask({2048{1'b1}}, 70));

    // random round trips
    for (int i = 0; i < 40; i++) begin
      logic [31:0] p = $urandom % 2400;
      int len = (i % 2 == 0) ? lens[$urandom % 9] : int'($urandom % 257);
      d = rand_vec();
      save_and_check(p, len, d, (i % 7) == 3);
      restore_and_check(p, len, f_mask(d, len));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule